// File: doc/BRIEF.md
# Local Bus Cycle Sequencer

This block runs the local-bus side of a bridge that serves PCI target accesses. The target logic presents a request made of a byte start address, four byte enables, a direction, a single-or-burst flag and a beat count. The sequencer turns that request into an address phase and a train of data beats. It drives the local address, the byte-lane enables, the direction and a last-transfer strobe, and it marks each beat that completes so that the datapath can move a word into or out of its FIFO. The data words do not pass through this block.

Each request is taken in the idle state. The per-region settings are captured along with it: bus mode (multiplexed or separate address and data), the recovery count, the internal wait count, the ready-enable flag and the burst-terminate-enable flag. Beats can be stretched by internal wait states and by the active-low ready input. A burst that starts off a word boundary is split into one single beat and then an aligned burst. Long bursts are cut into chunks unless the burst-terminate input keeps them going. Recovery states separate the last beat of each segment from the next address phase or from idle.

Top module: `lbus_seq`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The address phase (`lb_ads` high for exactly one cycle) follows in the next cycle, and `req_valid` has no effect while the block is busy.
- R2: On every write beat, `lb_be` equals the byte enables of the request (bit n enables byte lane n).
- R3: A single read makes exactly one data beat. That beat carries the requested byte enables and has `lb_blast` high.
- R4: On every beat of an aligned burst read, `lb_be` is 4'b1111, whatever byte enables were requested.
- R5: A burst whose address has nonzero bits [1:0] first makes one single beat at that address, with the requested byte enables and `lb_blast` high. If beats remain, a new address phase follows at the next word boundary (address bits [1:0] = 00) for the remaining len-1 beats.
- R6: Within a burst segment, `lb_addr` grows by 4 after each completed beat. A request of len beats (0 taken as 1; always 1 when not a burst) makes exactly len completed beats, and `lb_blast` is high during the final one.
- R7: If burst-terminate support is disabled, or `lb_bterm_n` is high, a burst segment ends after BURST_MAX (4) beats with `lb_blast`. A recovery period and a new address phase at the following word then come before the rest of the burst.
- R8: With burst-terminate support enabled and `lb_bterm_n` low, no chunk limit applies. `lb_blast` is raised only on the final beat, on a read while `rdfifo_full` is high, or on a write while `wrfifo_empty` is high. A beat completed under such a FIFO condition ends the whole request.
- R9: In multiplexed mode (`cfg_muxed`=1), after the last beat of a segment the bus stays quiet for max(1, `cfg_nxda`) cycles.
- R10: In non-multiplexed mode, exactly `cfg_nxda` (0 to 3) quiet cycles follow the last beat of a segment. With 0, the next address phase or idle follows at once.
- R11: Each beat first spends `cfg_wait` (0 to 3) cycles in the data state. Only after that can `lb_beat_done` go high, and `lb_addr` holds steady until the beat completes.
- R12: With `cfg_rdy_en`=1, a beat completes only in a cycle where `lb_ready_n` is low after its wait states. With `cfg_rdy_en`=0, `lb_ready_n` is ignored.
- R13: After reset the block is idle. `req_ready` is high, the strobes are low, `lb_be` is 0 and `lb_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle, able to take a request |
| req_addr | input | AW | Byte start address |
| req_be | input | 4 | Requested byte enables, active high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst, 0 = single |
| req_len | input | LW | Beat count for a burst |
| cfg_muxed | input | 1 | Region uses multiplexed address/data bus |
| cfg_nxda | input | 2 | Recovery count for the region |
| cfg_wait | input | 2 | Internal wait states per beat |
| cfg_rdy_en | input | 1 | Ready input controls beat completion |
| cfg_bterm_en | input | 1 | Burst-terminate input honoured |
| rdfifo_full | input | 1 | Read FIFO has no room |
| wrfifo_empty | input | 1 | Write FIFO has no data |
| lb_ready_n | input | 1 | Active-low beat ready from the local device |
| lb_bterm_n | input | 1 | Active-low burst-terminate from the local device |
| lb_ads | output | 1 | Address phase strobe |
| lb_dvalid | output | 1 | Data phase in progress |
| lb_beat_done | output | 1 | Current beat completes this cycle |
| lb_blast | output | 1 | Current beat is the last of its segment |
| lb_wr | output | 1 | Direction of the current access |
| lb_be | output | 4 | Byte-lane enables of the current access |
| lb_addr | output | AW | Local address |

## Verification
The bench targets the unaligned burst start. A design that gets it wrong would burst from the odd address, or would go on to the aligned part without a fresh address phase at the next word. It checks that byte lanes switch to all-ones only on aligned burst reads; a faulty lane choice shows up as partial lanes on a burst read or as forced lanes on a write. It covers the chunk boundary when burst-terminate is held and when it is not, and an early FIFO stop that must end the request, not just the chunk. Recovery counts of zero and one in both bus modes, and wait states combined with a toggling and an ignored ready input, show whether the cycle counts are off by one.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DATA  = 2'd2,
        ST_RECOV = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic       muxed;
        logic [1:0] nxda;
        logic [1:0] wait_n;
        logic       rdy_en;
        logic       bterm_en;
    } region_cfg_t;

    // Quiet cycles after the last beat of a segment.
    function automatic logic [1:0] recov_len(input logic muxed, input logic [1:0] nxda);
        return (muxed && nxda == 2'd0) ? 2'd1 : nxda;
    endfunction

    // Byte lanes driven: forced full only on the aligned part of a burst read.
    function automatic logic [3:0] lane_sel(input logic write, input logic single,
                                            input logic [3:0] be);
        return (write || single) ? be : 4'b1111;
    endfunction

endpackage

// File: rtl/lbus_beat_timer.sv
module lbus_beat_timer (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       active,
    input  logic [1:0] wait_cfg,
    input  logic       rdy_en,
    input  logic       ready_n,
    output logic       beat_ok
);
    logic [1:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            wcnt_q <= 2'd0;
        else if (load)
            wcnt_q <= wait_cfg;
        else if (active && wcnt_q != 2'd0)
            wcnt_q <= wcnt_q - 2'd1;
    end

    assign beat_ok = active && (wcnt_q == 2'd0) && (!rdy_en || !ready_n);
endmodule

// File: rtl/lbus_term_logic.sv
module lbus_term_logic #(
    parameter int LW        = 8,
    parameter int BURST_MAX = 4,
    parameter int CW        = 3
) (
    input  logic          write,
    input  logic          single,
    input  logic [LW-1:0] rem,
    input  logic [CW-1:0] chunk,
    input  logic          bterm_en,
    input  logic          bterm_n,
    input  logic          rdfifo_full,
    input  logic          wrfifo_empty,
    output logic          blast,
    output logic          end_xfer
);
    logic fifo_stop, chunk_end, hold_on;

    always_comb begin
        fifo_stop = write ? wrfifo_empty : rdfifo_full;
        end_xfer  = (rem == LW'(1)) || fifo_stop;
        chunk_end = !single && (chunk == CW'(BURST_MAX - 1));
        hold_on   = bterm_en && !bterm_n;
        blast     = single || end_xfer || (chunk_end && !hold_on);
    end
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
    import lbus_pkg::*;
#(
    parameter int AW        = 16,
    parameter int LW        = 8,
    parameter int BURST_MAX = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_be,
    input  logic          req_write,
    input  logic          req_burst,
    input  logic [LW-1:0] req_len,
    input  logic          cfg_muxed,
    input  logic [1:0]    cfg_nxda,
    input  logic [1:0]    cfg_wait,
    input  logic          cfg_rdy_en,
    input  logic          cfg_bterm_en,
    input  logic          rdfifo_full,
    input  logic          wrfifo_empty,
    input  logic          lb_ready_n,
    input  logic          lb_bterm_n,
    output logic          lb_ads,
    output logic          lb_dvalid,
    output logic          lb_beat_done,
    output logic          lb_blast,
    output logic          lb_wr,
    output logic [3:0]    lb_be,
    output logic [AW-1:0] lb_addr
);
    localparam int CW = $clog2(BURST_MAX + 1);

    seq_state_t    state_q;
    region_cfg_t   cfg_q;
    logic [AW-1:0] addr_q;
    logic [3:0]    be_q;
    logic          wr_q, single_q, done_q;
    logic [LW-1:0] rem_q;
    logic [CW-1:0] chunk_q;
    logic [1:0]    rcnt_q;

    logic          in_data, beat_ok, beat_done, blast_c, end_c, tload;
    logic [1:0]    rec_n;
    logic [AW-1:0] word_next;

    assign in_data   = (state_q == ST_DATA);
    assign beat_done = in_data && beat_ok;
    assign tload     = (state_q == ST_ADDR) || (beat_done && !blast_c);
    assign rec_n     = recov_len(cfg_q.muxed, cfg_q.nxda);
    assign word_next = {addr_q[AW-1:2] + 1'b1, 2'b00};

    lbus_beat_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .active   (in_data),
        .wait_cfg (cfg_q.wait_n),
        .rdy_en   (cfg_q.rdy_en),
        .ready_n  (lb_ready_n),
        .beat_ok  (beat_ok)
    );

    lbus_term_logic #(.LW(LW), .BURST_MAX(BURST_MAX), .CW(CW)) u_term (
        .write        (wr_q),
        .single       (single_q),
        .rem          (rem_q),
        .chunk        (chunk_q),
        .bterm_en     (cfg_q.bterm_en),
        .bterm_n      (lb_bterm_n),
        .rdfifo_full  (rdfifo_full),
        .wrfifo_empty (wrfifo_empty),
        .blast        (blast_c),
        .end_xfer     (end_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            addr_q   <= '0;
            be_q     <= '0;
            wr_q     <= 1'b0;
            single_q <= 1'b0;
            done_q   <= 1'b0;
            rem_q    <= '0;
            chunk_q  <= '0;
            rcnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    cfg_q    <= '{muxed: cfg_muxed, nxda: cfg_nxda, wait_n: cfg_wait,
                                  rdy_en: cfg_rdy_en, bterm_en: cfg_bterm_en};
                    addr_q   <= req_addr;
                    be_q     <= req_be;
                    wr_q     <= req_write;
                    single_q <= !req_burst || (req_addr[1:0] != 2'b00);
                    rem_q    <= (!req_burst || req_len == '0) ? LW'(1) : req_len;
                    state_q  <= ST_ADDR;
                end
                ST_ADDR: begin
                    chunk_q <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: if (beat_done) begin
                    rem_q <= rem_q - 1'b1;
                    if (blast_c) begin
                        done_q <= end_c;
                        if (!end_c) begin
                            addr_q   <= word_next;
                            single_q <= 1'b0;
                        end
                        if (rec_n == 2'd0)
                            state_q <= end_c ? ST_IDLE : ST_ADDR;
                        else begin
                            rcnt_q  <= rec_n;
                            state_q <= ST_RECOV;
                        end
                    end else begin
                        addr_q  <= addr_q + AW'(4);
                        chunk_q <= chunk_q + 1'b1;
                    end
                end
                ST_RECOV: begin
                    if (rcnt_q == 2'd1)
                        state_q <= done_q ? ST_IDLE : ST_ADDR;
                    else
                        rcnt_q <= rcnt_q - 2'd1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign lb_ads       = (state_q == ST_ADDR);
    assign lb_dvalid    = in_data;
    assign lb_beat_done = beat_done;
    assign lb_blast     = in_data && blast_c;
    assign lb_wr        = wr_q;
    assign lb_be        = (lb_ads || in_data) ? lane_sel(wr_q, single_q, be_q) : 4'b0000;
    assign lb_addr      = addr_q;
endmodule

// File: rtl/lbus_seq_chk.sv
module lbus_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          lb_ads,
    input logic          lb_dvalid,
    input logic          lb_beat_done,
    input logic          lb_blast,
    input logic [AW-1:0] lb_addr,
    input logic          lb_ready_n,
    input logic          rdy_en_q,
    input logic          muxed_q
);
    // R1: a taken request is followed by the address phase
    p_ads_after_take_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> lb_ads)
        else $error("p_ads_after_take_r1");

    // R1: no request is taken while busy
    p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (rst)
        (lb_ads || lb_dvalid) |-> !req_ready)
        else $error("p_busy_not_ready_r1");

    // R6: last-transfer strobe only inside a data phase
    p_blast_in_data_r6: assert property (@(posedge clk) disable iff (rst)
        lb_blast |-> lb_dvalid)
        else $error("p_blast_in_data_r6");

    // R11: address holds until the beat completes
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (lb_dvalid && !lb_beat_done) |=> $stable(lb_addr))
        else $error("p_addr_hold_r11");

    // R12: with ready enabled a beat only completes when ready is low
    p_ready_gate_r12: assert property (@(posedge clk) disable iff (rst)
        (lb_beat_done && rdy_en_q) |-> !lb_ready_n)
        else $error("p_ready_gate_r12");

    // R9: multiplexed mode always leaves a quiet cycle after a segment
    p_mux_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (lb_beat_done && lb_blast && muxed_q) |=> (!lb_ads && !lb_dvalid))
        else $error("p_mux_quiet_r9");

    // R1: address and data phases never overlap
    p_phase_excl_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lb_ads, lb_dvalid, req_ready}))
        else $error("p_phase_excl_r1");
endmodule

bind lbus_seq lbus_seq_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .lb_ads       (lb_ads),
    .lb_dvalid    (lb_dvalid),
    .lb_beat_done (lb_beat_done),
    .lb_blast     (lb_blast),
    .lb_addr      (lb_addr),
    .lb_ready_n   (lb_ready_n),
    .rdy_en_q     (cfg_q.rdy_en),
    .muxed_q      (cfg_q.muxed)
);

// File: tb/lbus_seq_test.sv
module lbus_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int LW = 8;
    localparam int BMAX = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [3:0] req_be = '0;
    logic req_write = 1'b0, req_burst = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic cfg_muxed = 1'b0, cfg_rdy_en = 1'b0, cfg_bterm_en = 1'b0;
    logic [1:0] cfg_nxda = '0, cfg_wait = '0;
    logic rdfifo_full = 1'b0, wrfifo_empty = 1'b0;
    logic lb_ready_n = 1'b1, lb_bterm_n = 1'b1;
    logic lb_ads, lb_dvalid, lb_beat_done, lb_blast, lb_wr;
    logic [3:0] lb_be;
    logic [AW-1:0] lb_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lbus_seq #(.AW(AW), .LW(LW), .BURST_MAX(BMAX)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be(req_be), .req_write(req_write),
        .req_burst(req_burst), .req_len(req_len), .cfg_muxed(cfg_muxed),
        .cfg_nxda(cfg_nxda), .cfg_wait(cfg_wait), .cfg_rdy_en(cfg_rdy_en),
        .cfg_bterm_en(cfg_bterm_en), .rdfifo_full(rdfifo_full),
        .wrfifo_empty(wrfifo_empty), .lb_ready_n(lb_ready_n),
        .lb_bterm_n(lb_bterm_n), .lb_ads(lb_ads), .lb_dvalid(lb_dvalid),
        .lb_beat_done(lb_beat_done), .lb_blast(lb_blast), .lb_wr(lb_wr),
        .lb_be(lb_be), .lb_addr(lb_addr)
    );

    int checks = 0, failures = 0, cyc = 0, beats = 0;
    string tag = "R13";

    // Behavioural reference: 0 idle, 1 address, 2 data, 3 quiet
    int m_state = 0, m_addr = 0, m_be = 0, m_wr = 0, m_single = 0;
    int m_rem = 0, m_chunk = 0, m_wcnt = 0, m_rcnt = 0, m_done = 0;
    int c_mux = 0, c_nxda = 0, c_wait = 0, c_rdy = 0, c_bt = 0;

    function automatic bit m_endx();
        bit stop = m_wr ? bit'(wrfifo_empty) : bit'(rdfifo_full);
        return (m_rem == 1) || stop;
    endfunction

    function automatic bit m_blast();
        bit chunk_end = !m_single && (m_chunk == BMAX - 1);
        bit keep = c_bt && !lb_bterm_n;
        return m_single || m_endx() || (chunk_end && !keep);
    endfunction

    function automatic bit m_ok();
        return (m_state == 2) && (m_wcnt == 0) && (!c_rdy || !lb_ready_n);
    endfunction

    function automatic logic [25:0] m_out();
        logic [3:0] be;
        if (m_state == 1 || m_state == 2)
            be = (m_wr || m_single) ? m_be[3:0] : 4'hF;
        else
            be = 4'h0;
        return {m_state == 0, m_state == 1, m_state == 2,
                (m_state == 2) && m_blast(), m_ok(), m_wr[0], be, m_addr[AW-1:0]};
    endfunction

    task automatic m_advance();
        if (rst) begin
            m_state = 0; m_addr = 0; m_be = 0; m_wr = 0; m_single = 0;
            m_rem = 0; m_chunk = 0; m_wcnt = 0; m_rcnt = 0; m_done = 0;
            c_mux = 0; c_nxda = 0; c_wait = 0; c_rdy = 0; c_bt = 0;
            return;
        end
        case (m_state)
            0: if (req_valid) begin
                c_mux = cfg_muxed; c_nxda = cfg_nxda; c_wait = cfg_wait;
                c_rdy = cfg_rdy_en; c_bt = cfg_bterm_en;
                m_addr = req_addr; m_be = req_be; m_wr = req_write;
                m_single = !req_burst || (req_addr % 4 != 0);
                m_rem = (!req_burst || req_len == 0) ? 1 : int'(req_len);
                m_state = 1;
            end
            1: begin m_wcnt = c_wait; m_chunk = 0; m_state = 2; end
            2: begin
                if (m_ok()) begin
                    int rec = (c_mux && c_nxda == 0) ? 1 : c_nxda;
                    bit bl = m_blast();
                    bit ex = m_endx();
                    beats++;
                    m_rem--;
                    if (bl) begin
                        m_done = ex;
                        if (!ex) begin
                            m_addr = ((m_addr / 4 + 1) * 4) % (1 << AW);
                            m_single = 0;
                        end
                        if (rec == 0) m_state = ex ? 0 : 1;
                        else begin m_rcnt = rec; m_state = 3; end
                    end else begin
                        m_addr = (m_addr + 4) % (1 << AW);
                        m_chunk++;
                        m_wcnt = c_wait;
                    end
                end else if (m_wcnt > 0) m_wcnt--;
            end
            default: begin
                if (m_rcnt == 1) m_state = m_done ? 0 : 1;
                else m_rcnt--;
            end
        endcase
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Compare one cycle, then move the reference and wait for the next cycle.
    task automatic step();
        logic [25:0] act, exp;
        #1;
        exp = m_out();
        act = {req_ready, lb_ads, lb_dvalid, lb_blast, lb_beat_done, lb_wr, lb_be, lb_addr};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
        end
        m_advance();
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog %s act=running exp=finished", tag);
            finish_run();
        end
        @(negedge clk);
    endtask

    // rpat: 0 ready low, 1 ready toggling, 2 ready high. fk: cycle offset where FIFO flags rise (0 = never)
    task automatic xfer(input int a, input int be, input int wr, input int bu, input int ln,
                        input int mux, input int nx, input int wt, input int re, input int bt,
                        input int bterm, input int rpat, input int fk, input int exp_beats,
                        input string t);
        int k = 0;
        tag = t;
        req_addr = a[AW-1:0]; req_be = be[3:0]; req_write = wr[0]; req_burst = bu[0];
        req_len = ln[LW-1:0]; cfg_muxed = mux[0]; cfg_nxda = nx[1:0]; cfg_wait = wt[1:0];
        cfg_rdy_en = re[0]; cfg_bterm_en = bt[0]; lb_bterm_n = !bterm[0];
        beats = 0;
        req_valid = 1'b1;
        do begin
            lb_ready_n = (rpat == 0) ? 1'b0 : (rpat == 1) ? (cyc % 3 != 0) : 1'b1;
            rdfifo_full  = (fk > 0 && k >= fk);
            wrfifo_empty = (fk > 0 && k >= fk);
            step();
            req_valid = 1'b0;
            k++;
        end while (m_state != 0 && k < 400);
        rdfifo_full = 1'b0; wrfifo_empty = 1'b0;
        step();
        step();
        checks++;
        if (beats != exp_beats) begin
            failures++;
            $display("FAIL %s beat count act=%0d exp=%0d", t, beats, exp_beats);
        end
    endtask

    initial begin
        @(negedge clk);
        tag = "R13";
        for (int i = 0; i < 3; i++) step();
        rst = 1'b0;
        step();
        // R3 single read, lanes pass, non-mux zero recovery (R10)
        xfer(32'h0104, 4'b0110, 0, 0, 7, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R3");
        // R2 write burst keeps requested lanes, non-mux recovery 2 (R10)
        xfer(32'h0200, 4'b1010, 1, 1, 3, 0, 2, 0, 0, 0, 0, 0, 0, 3, "R2");
        // R4 burst read forced lanes, chunks of 4 then 2 (R7), mux recovery 1 (R9)
        xfer(32'h0300, 4'b0001, 0, 1, 6, 1, 0, 0, 0, 0, 0, 0, 0, 6, "R4");
        // R5 unaligned burst start
        xfer(32'h1003, 4'b1000, 0, 1, 3, 0, 1, 0, 0, 0, 0, 0, 0, 3, "R5");
        // R6 aligned burst, address steps by 4, blast on last
        xfer(32'hFFF8, 4'b0011, 0, 1, 4, 0, 1, 0, 0, 0, 0, 0, 0, 4, "R6");
        // R7 terminate enabled but not asserted: still chunked
        xfer(32'h0400, 4'b1111, 1, 1, 5, 0, 0, 0, 0, 1, 0, 0, 0, 5, "R7");
        // R8 terminate held, read FIFO fills, transfer stops early
        xfer(32'h0500, 4'b1111, 0, 1, 9, 0, 0, 0, 0, 1, 1, 0, 5, 4, "R8");
        // R8 write, terminate held, no chunk cut
        xfer(32'h0600, 4'b0101, 1, 1, 6, 0, 0, 0, 0, 1, 1, 0, 0, 6, "R8");
        // R11 wait states with R12 toggling ready, mux recovery 3 (R9)
        xfer(32'h0700, 4'b1111, 0, 1, 3, 1, 3, 2, 1, 0, 0, 1, 0, 3, "R11");
        // R12 ready disabled and held high: ignored
        xfer(32'h0800, 4'b1100, 1, 1, 2, 0, 0, 1, 0, 0, 0, 2, 0, 2, "R12");
        // R9 multiplexed single write with zero setting still gets one quiet cycle
        xfer(32'h0900, 4'b0001, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
        // R10 non-mux burst with zero recovery across a chunk boundary
        xfer(32'h0A00, 4'b1111, 0, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, 5, "R10");
        // R1 request held high while busy: only taken again in idle
        tag = "R1";
        req_addr = 16'h0B00; req_be = 4'b1111; req_write = 1'b0; req_burst = 1'b1;
        req_len = 8'd2; cfg_muxed = 1'b0; cfg_nxda = 2'd1; cfg_wait = 2'd0;
        cfg_rdy_en = 1'b0; cfg_bterm_en = 1'b0; lb_ready_n = 1'b0;
        req_valid = 1'b1;
        for (int i = 0; i < 14; i++) begin
            if (i == 3) req_addr = 16'h0C00;
            step();
        end
        req_valid = 1'b0;
        for (int i = 0; i < 12; i++) step();
        finish_run();
    end
endmodule